// File: doc/BRIEF.md
# Two-Channel Conversion Sequencer

This controller decides which input channel is converted next, and when. It counts out each conversion as a programmable number of oscillator clocks. It holds a busy indication while conversions are running. At the end of each conversion it issues a one-cycle strobe tagged with the channel number. The analog converter that acts on these strobes is outside the block. The `clk` input is the oscillator clock.

A start pulse launches a run. The mode, the channel-enable mask and the cycle length are latched at that moment, so changes made to them during a run have no effect. A run takes one of three forms:

- a single conversion of channel 0;
- one ascending pass over the enabled channels;
- an endless rotation over the enabled channels, stopped only by an abort pulse.

The programmed cycle length is raised to a floor that depends on which oscillator is selected. A status field reports whether channel scanning is off, running normally, or was refused because no channel was enabled. A small wrapping counter reports how many conversions have completed since the last start.

Top module: `conv_sequencer`

## Requirements
- R1: A start pulse seen while idle (abort low, valid mode) raises `busy_o` at the next clock edge, and the first conversion begins at once. In single mode that conversion is on channel 0. In scan modes it is on the lowest enabled channel.
- R2: An abort pulse drops `busy_o` at the next edge, and the strobe for the conversion in progress is never issued. When start and abort arrive together while idle, no run begins.
- R3: The conversion length is the larger of `ncyc_i` and a floor. The floor is 21 when `osc_lp_i`=0 (fast oscillator) and 18 when `osc_lp_i`=1 (low-power oscillator).
- R4: Every conversion keeps `busy_o` high for exactly the clamped length in clocks. `conv_strobe_o` is high for one cycle only, the last cycle of the conversion, with `conv_chan_o` naming the channel.
- R5: The `mode_i` codes are decoded as follows:
  - 000 and 001 run one conversion of channel 0 and then return to idle.
  - 100 and 101 run one pass over the enabled channels and then return to idle.
  - 110 and 111 rotate over the enabled channels until aborted.
- R6: In the scan modes, a channel with its enable bit at 0 is skipped. Channel 0 is converted before channel 1, and the rotation wraps to the lowest enabled channel. Channel n is enabled by bit n of `chan_en_i`.
- R7: `seq_stat_o` is updated at each accepted start:
  - 00 for single mode;
  - 01 for a scan mode with at least one channel enabled;
  - 11 for a scan mode with no channel enabled, in which case `busy_o` stays low.
  It resets to 00 and keeps its value through an abort.
- R8: `acc_cnt_o` clears at each accepted start. It increases by one at the edge that ends each completed conversion, and wraps modulo 16.
- R9: A start pulse is ignored while busy. The reserved codes 010 and 011 are ignored entirely: `busy_o` stays low and the status is unchanged.
- R10: Changes to mode, enables, oscillator select or cycle length during a run do not alter the current run's channel order or timing.
- R11: After reset the outputs are idle: busy 0, strobe 0, status 00, count 0, channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle run request |
| abort_i | input | 1 | Single-cycle stop request, wins over start |
| mode_i | input | 3 | Run mode code |
| chan_en_i | input | NCH | Scan enable per channel |
| osc_lp_i | input | 1 | 1 selects the low-power oscillator floor |
| ncyc_i | input | CW | Requested clocks per conversion |
| conv_chan_o | output | IW | Channel of the current conversion |
| conv_strobe_o | output | 1 | Last-cycle strobe of each conversion |
| busy_o | output | 1 | A conversion is in progress |
| seq_stat_o | output | 2 | Scan status code |
| acc_cnt_o | output | ACC_W | Conversions completed since start, modulo 16 |

## Verification
A start sampled at edge E shows busy and the launched channel from the cycle after E. The strobe of a conversion of length L is therefore due in the L-th cycle after E. The next conversion's first cycle, or the return to idle, follows in the cycle after that, together with the incremented completion count. Abort takes effect in the cycle after its edge. The bench drives and samples on the falling clock edge and counts falling edges from the start edge, so each expected value is compared in exactly the cycle in which it is due.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    RUN_SINGLE = 2'd0,
    RUN_PASS   = 2'd1,
    RUN_LOOP   = 2'd2
  } run_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seq_state_e;

  localparam logic [1:0] STAT_OFF = 2'b00;
  localparam logic [1:0] STAT_OK  = 2'b01;
  localparam logic [1:0] STAT_ERR = 2'b11;

endpackage

// File: rtl/conv_len_clamp.sv
module conv_len_clamp #(
  parameter int CW     = 8,
  parameter int MIN_HS = 21,
  parameter int MIN_LP = 18
) (
  input  logic [CW-1:0] ncyc_i,
  input  logic          osc_lp_i,
  output logic [CW-1:0] len_o
);

  localparam logic [CW-1:0] FLOOR_HS = CW'(MIN_HS);
  localparam logic [CW-1:0] FLOOR_LP = CW'(MIN_LP);

  logic [CW-1:0] floor_val;

  always_comb begin
    floor_val = osc_lp_i ? FLOOR_LP : FLOOR_HS;
    len_o     = (ncyc_i > floor_val) ? ncyc_i : floor_val;
  end

endmodule

// File: rtl/chan_picker.sv
module chan_picker #(
  parameter int NCH = 2,
  parameter int IW  = 1
) (
  input  logic [NCH-1:0] en_i,
  input  logic [IW-1:0]  cur_i,
  output logic [IW-1:0]  first_o,
  output logic           first_vld_o,
  output logic [IW-1:0]  next_o,
  output logic           next_vld_o
);

  logic [NCH-1:0] above;

  for (genvar g = 0; g < NCH; g++) begin : g_above
    assign above[g] = en_i[g] && (g > int'(cur_i));
  end

  always_comb begin
    first_o     = '0;
    first_vld_o = 1'b0;
    next_o      = '0;
    next_vld_o  = 1'b0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (en_i[c]) begin
        first_o     = IW'(c);
        first_vld_o = 1'b1;
      end
      if (above[c]) begin
        next_o     = IW'(c);
        next_vld_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int IW    = 1,
  parameter int CW    = 8,
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [2:0]       mode_i,
  input  logic [NCH-1:0]   en_i,
  input  logic [CW-1:0]    len_i,
  input  logic [IW-1:0]    first_i,
  input  logic             first_vld_i,
  input  logic [IW-1:0]    next_i,
  input  logic             next_vld_i,
  output logic [NCH-1:0]   pick_en_o,
  output logic [IW-1:0]    chan_o,
  output logic             busy_o,
  output logic             strobe_o,
  output logic [1:0]       stat_o,
  output logic [ACC_W-1:0] acc_o
);

  seq_state_e      st_q,   st_d;
  run_kind_e       kind_q, kind_d;
  logic [CW-1:0]   cnt_q,  cnt_d;
  logic [CW-1:0]   len_q,  len_d;
  logic [IW-1:0]   chan_q, chan_d;
  logic [NCH-1:0]  en_q,   en_d;
  logic [1:0]      stat_q, stat_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic            conv_end;
  logic            upd_en;

  assign conv_end  = (st_q == ST_CONV) && (cnt_q == len_q);
  assign upd_en    = start_i | abort_i | (st_q == ST_CONV);
  assign pick_en_o = (st_q == ST_CONV) ? en_q : en_i;

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    chan_d = chan_q;
    en_d   = en_q;
    stat_d = stat_q;
    acc_d  = acc_q;
    if (abort_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else if (st_q == ST_IDLE) begin
      if (start_i) begin
        unique case (mode_i)
          3'b000, 3'b001: begin
            st_d   = ST_CONV;
            kind_d = RUN_SINGLE;
            cnt_d  = CW'(1);
            len_d  = len_i;
            chan_d = '0;
            stat_d = STAT_OFF;
            acc_d  = '0;
          end
          3'b100, 3'b101, 3'b110, 3'b111: begin
            acc_d = '0;
            if (first_vld_i) begin
              st_d   = ST_CONV;
              kind_d = mode_i[1] ? RUN_LOOP : RUN_PASS;
              cnt_d  = CW'(1);
              len_d  = len_i;
              chan_d = first_i;
              en_d   = en_i;
              stat_d = STAT_OK;
            end else begin
              stat_d = STAT_ERR;
            end
          end
          default: ;
        endcase
      end
    end else if (conv_end) begin
      acc_d = acc_q + 1'b1;
      cnt_d = CW'(1);
      unique case (kind_q)
        RUN_PASS: begin
          if (next_vld_i) begin
            chan_d = next_i;
          end else begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end
        end
        RUN_LOOP: chan_d = next_vld_i ? next_i : first_i;
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= RUN_SINGLE;
      cnt_q  <= '0;
      len_q  <= '0;
      chan_q <= '0;
      en_q   <= '1;
      stat_q <= STAT_OFF;
      acc_q  <= '0;
    end else if (upd_en) begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      chan_q <= chan_d;
      en_q   <= en_d;
      stat_q <= stat_d;
      acc_q  <= acc_d;
    end
  end

  assign busy_o   = (st_q == ST_CONV);
  assign strobe_o = conv_end;
  assign chan_o   = chan_q;
  assign stat_o   = stat_q;
  assign acc_o    = acc_q;

  // R1
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !abort_i && !busy_o && (mode_i[2:1] == 2'b00) |=> busy_o && (chan_o == '0));

  // R2
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_o && !strobe_o);

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o == STAT_ERR) |-> !busy_o);

  // R8
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o && !abort_i |=> acc_o == $past(acc_o) + 1'b1);

  // R6
  chan_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (stat_o == STAT_OK) |-> en_q[chan_q]);

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int NCH    = 2,
  parameter int CW     = 8,
  parameter int ACC_W  = 4,
  parameter int MIN_HS = 21,
  parameter int MIN_LP = 18,
  localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [2:0]       mode_i,
  input  logic [NCH-1:0]   chan_en_i,
  input  logic             osc_lp_i,
  input  logic [CW-1:0]    ncyc_i,
  output logic [IW-1:0]    conv_chan_o,
  output logic             conv_strobe_o,
  output logic             busy_o,
  output logic [1:0]       seq_stat_o,
  output logic [ACC_W-1:0] acc_cnt_o
);

  logic [CW-1:0]  len;
  logic [NCH-1:0] pick_en;
  logic [IW-1:0]  first_idx, next_idx;
  logic           first_vld, next_vld;

  conv_len_clamp #(
    .CW(CW), .MIN_HS(MIN_HS), .MIN_LP(MIN_LP)
  ) u_clamp (
    .ncyc_i  (ncyc_i),
    .osc_lp_i(osc_lp_i),
    .len_o   (len)
  );

  chan_picker #(
    .NCH(NCH), .IW(IW)
  ) u_pick (
    .en_i       (pick_en),
    .cur_i      (conv_chan_o),
    .first_o    (first_idx),
    .first_vld_o(first_vld),
    .next_o     (next_idx),
    .next_vld_o (next_vld)
  );

  seq_ctrl #(
    .NCH(NCH), .IW(IW), .CW(CW), .ACC_W(ACC_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .mode_i     (mode_i),
    .en_i       (chan_en_i),
    .len_i      (len),
    .first_i    (first_idx),
    .first_vld_i(first_vld),
    .next_i     (next_idx),
    .next_vld_i (next_vld),
    .pick_en_o  (pick_en),
    .chan_o     (conv_chan_o),
    .busy_o     (busy_o),
    .strobe_o   (conv_strobe_o),
    .stat_o     (seq_stat_o),
    .acc_o      (acc_cnt_o)
  );

endmodule

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;

  logic       clk;
  logic       rst_n;
  logic       start_i, abort_i, osc_lp_i;
  logic [2:0] mode_i;
  logic [1:0] chan_en_i;
  logic [7:0] ncyc_i;
  logic [0:0] conv_chan_o;
  logic       conv_strobe_o, busy_o;
  logic [1:0] seq_stat_o;
  logic [3:0] acc_cnt_o;

  int n_cmp  = 0;
  int n_fail = 0;
  int exp_stat = 0;

  conv_sequencer i_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .mode_i(mode_i), .chan_en_i(chan_en_i), .osc_lp_i(osc_lp_i), .ncyc_i(ncyc_i),
    .conv_chan_o(conv_chan_o), .conv_strobe_o(conv_strobe_o), .busy_o(busy_o),
    .seq_stat_o(seq_stat_o), .acc_cnt_o(acc_cnt_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input logic [7:0] nc, input logic lp);
    int fl;
    fl = lp ? 18 : 21;
    return (int'(nc) > fl) ? int'(nc) : fl;
  endfunction

  function automatic int first_ch(input logic [1:0] en);
    return en[0] ? 0 : 1;
  endfunction

  function automatic int wrap_next(input logic [1:0] en, input int ch);
    if (ch == 0 && en[1]) return 1;
    return first_ch(en);
  endfunction

  // One run from a start pulse; loops > 0 only used for rotating modes.
  task automatic do_run(input logic [2:0] m, input logic [1:0] en, input logic lp,
                        input logic [7:0] nc, input int loops, input bit poke);
    int len, kind, nconv, ch;
    len  = exp_len(nc, lp);
    kind = !m[2] ? 0 : (m[1] ? 2 : 1);
    mode_i = m; chan_en_i = en; osc_lp_i = lp; ncyc_i = nc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (m[2:1] == 2'b01) begin
      chk("R9 reserved busy", int'(busy_o), 0);
      chk("R9 reserved status", int'(seq_stat_o), exp_stat);
      @(negedge clk);
      chk("R9 reserved busy later", int'(busy_o), 0);
      return;
    end
    if (kind != 0 && en == 2'b00) begin
      exp_stat = 3;
      chk("R7 error status", int'(seq_stat_o), 3);
      chk("R7 error busy", int'(busy_o), 0);
      @(negedge clk);
      chk("R7 error busy later", int'(busy_o), 0);
      return;
    end
    exp_stat = (kind == 0) ? 0 : 1;
    chk("R7 status", int'(seq_stat_o), exp_stat);
    nconv = (kind == 0) ? 1 : (kind == 1) ? int'(en[0]) + int'(en[1]) : loops;
    ch    = (kind == 0) ? 0 : first_ch(en);
    for (int k = 0; k < nconv; k++) begin
      for (int n = 1; n <= len; n++) begin
        if (n == 1) chk("R1 busy during conversion", int'(busy_o), 1);
        if (n == len) begin
          chk("R4 strobe at last cycle", int'(conv_strobe_o), 1);
          chk(kind == 0 ? "R5 channel" : "R6 channel", int'(conv_chan_o), ch);
        end else if (n == 1 || n == len - 1) begin
          chk("R4 no early strobe", int'(conv_strobe_o), 0);
        end
        if (poke && k == 0 && n == 2) begin
          start_i = 1'b1; mode_i = 3'b110; chan_en_i = ~en; ncyc_i = 8'd60; osc_lp_i = ~lp;
        end
        if (poke && k == 0 && n == 3) begin
          start_i = 1'b0; mode_i = m; chan_en_i = en; ncyc_i = nc; osc_lp_i = lp;
        end
        @(negedge clk);
      end
      if (kind != 0) ch = wrap_next(en, ch);
    end
    if (kind != 2) begin
      chk(poke ? "R10 run ends as latched" : "R5 idle after run", int'(busy_o), 0);
      chk("R8 completion count", int'(acc_cnt_o), nconv % 16);
    end else begin
      chk("R5 rotation continues", int'(busy_o), 1);
      chk("R6 wrap channel", int'(conv_chan_o), ch);
      chk("R8 completion count", int'(acc_cnt_o), nconv % 16);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      chk("R2 abort busy", int'(busy_o), 0);
      chk("R2 abort strobe", int'(conv_strobe_o), 0);
      chk("R7 status kept on abort", int'(seq_stat_o), exp_stat);
    end
    @(negedge clk);
  endtask

  task automatic measure_len(input logic lp, input logic [7:0] nc);
    int cyc;
    cyc = 0;
    mode_i = 3'b000; osc_lp_i = lp; ncyc_i = nc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!conv_strobe_o && cyc < 300) begin
      cyc++;
      @(negedge clk);
    end
    chk("R3 clamped length", cyc + 1, exp_len(nc, lp));
    @(negedge clk);
    chk("R3 idle after measured run", int'(busy_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [2:0] modes [6];
    modes = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; mode_i = 3'b000;
    chan_en_i = 2'b11; osc_lp_i = 1'b0; ncyc_i = 8'd0;
    repeat (3) @(negedge clk);
    chk("R11 reset busy", int'(busy_o), 0);
    chk("R11 reset strobe", int'(conv_strobe_o), 0);
    chk("R11 reset status", int'(seq_stat_o), 0);
    chk("R11 reset count", int'(acc_cnt_o), 0);
    chk("R11 reset channel", int'(conv_chan_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 clamp boundaries
    measure_len(1'b0, 8'd0);
    measure_len(1'b0, 8'd21);
    measure_len(1'b0, 8'd22);
    measure_len(1'b1, 8'd18);
    measure_len(1'b1, 8'd19);
    measure_len(1'b1, 8'd5);
    measure_len(1'b0, 8'd255);

    // Directed modes
    do_run(3'b001, 2'b10, 1'b0, 8'd25, 0, 1'b0);   // R5 single ignores enables
    do_run(3'b100, 2'b11, 1'b1, 8'd20, 0, 1'b0);   // R6 pass 0 then 1
    do_run(3'b101, 2'b10, 1'b0, 8'd0,  0, 1'b0);   // R6 pass skips channel 0
    do_run(3'b110, 2'b11, 1'b0, 8'd0, 17, 1'b0);   // R8 wrap of count
    do_run(3'b111, 2'b10, 1'b1, 8'd0,  3, 1'b0);   // R6 single-channel rotation
    do_run(3'b100, 2'b00, 1'b0, 8'd30, 0, 1'b0);   // R7 empty set
    do_run(3'b010, 2'b11, 1'b0, 8'd30, 0, 1'b0);   // R9 reserved
    do_run(3'b011, 2'b01, 1'b1, 8'd30, 0, 1'b0);   // R9 reserved
    do_run(3'b100, 2'b11, 1'b0, 8'd23, 0, 1'b1);   // R9 R10 start and changes mid-run

    // R2 abort mid-conversion, then no late strobe
    begin
      int seen;
      seen = 0;
      mode_i = 3'b000; ncyc_i = 8'd30; osc_lp_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      chk("R2 abort mid busy", int'(busy_o), 0);
      for (int i = 0; i < 40; i++) begin
        if (conv_strobe_o) seen++;
        @(negedge clk);
      end
      chk("R2 no strobe after abort", seen, 0);
      chk("R8 count after aborted single", int'(acc_cnt_o), 0);
      exp_stat = 0;
    end

    // R2 start together with abort while idle
    mode_i = 3'b110; chan_en_i = 2'b11; start_i = 1'b1; abort_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; abort_i = 1'b0;
    chk("R2 start with abort", int'(busy_o), 0);
    chk("R2 status untouched", int'(seq_stat_o), exp_stat);
    @(negedge clk);

    // Constrained random runs
    for (int it = 0; it < 40; it++) begin
      logic [2:0] m;
      logic [1:0] en;
      logic       lp;
      logic [7:0] nc;
      m  = modes[$urandom % 6];
      en = 2'($urandom % 4);
      lp = 1'($urandom % 2);
      nc = 8'($urandom % 36);
      do_run(m, en, lp, nc, 1 + int'($urandom % 4), 1'($urandom % 4 == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule